// File: doc/BRIEF.md
# External-Context Vector Store Decoder

This block sits in a load/store issue path. It looks at one 32-bit instruction word per handshake, with the values already read for the base and index operands. It recognises the two forms of a privileged 16-byte vector store and forms the store address. It then places a store request in a one-entry output slot. The request carries the translation context taken from a separately programmed external context register, not from the live machine state.

A downstream memory pipe drains the slot through a valid/ready handshake. When the current state forbids the instruction, no request is made. Instead, a one-cycle exception flag is raised in the cycle after acceptance. Instruction words that match neither encoding are consumed silently: they produce no request and no flag.

Top module: `xctx_vst_issue`

## Requirements
- R1: An instruction is claimed only when insn[31:26] equals 31, insn[10:1] equals 807 or 775, and insn[0] is 0. Any other word that is accepted produces no store and no exception flag.
- R2: The source vector register number in the request is insn[25:21]. The base register number is insn[20:16].
- R3: The request address is the base plus the index, wrapped modulo 2^64, with bits [3:0] cleared. When insn[20:16] is 0, a literal zero replaces the base value.
- R4: The low-reuse hint in the request is 1 for extended opcode 775 and 0 for extended opcode 807.
- R5: The request carries the privilege, address-space and process-ID values of the external context as they stood at acceptance. Every request describes a 16-byte store.
- R6: When cur_user is 1 at acceptance of a claimed word, exc_priv is high for exactly the next cycle and no store is issued.
- R7: When cur_user is 0 and vec_en is 0 at acceptance of a claimed word, exc_vec is high for exactly the next cycle and no store is issued.
- R8: When both fault conditions hold, only exc_priv is raised. exc_priv and exc_vec are never high together.
- R9: While st_valid is 1 and st_ready is 0, the request stays valid and all of its fields stay unchanged.
- R10: in_ready is 1 exactly when the slot is empty or st_ready is 1. A claimed, permitted word accepted then appears on the request one cycle later.
- R11: While rst_n is 0 at a clock edge, st_valid, exc_priv and exc_vec are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands present |
| in_ready | output | 1 | Block can accept this cycle |
| insn | input | 32 | Instruction word, bit 31 = least significant |
| base_val | input | 64 | Value read for the base register field |
| index_val | input | 64 | Value read for the index register field |
| cur_user | input | 1 | Current state is user mode |
| vec_en | input | 1 | Vector unit enabled |
| xctx_user | input | 1 | External context privilege bit |
| xctx_as | input | 1 | External context address-space bit |
| xctx_pid | input | PID_W | External context process ID |
| st_valid | output | 1 | Store request present |
| st_ready | input | 1 | Downstream takes the request |
| st_addr | output | 64 | 16-byte aligned store address |
| st_vreg | output | 5 | Source vector register number |
| st_bytes | output | 5 | Store size in bytes, always 16 |
| st_user | output | 1 | Privilege used for translation |
| st_as | output | 1 | Address space used for translation |
| st_pid | output | PID_W | Process ID used for translation |
| st_low_reuse | output | 1 | Low-reuse cache hint |
| exc_priv | output | 1 | Privileged-instruction fault pulse |
| exc_vec | output | 1 | Vector-unavailable fault pulse |

## Verification
The assertions check several rules on every cycle. They cover address alignment, request stability under back-pressure, and that the two fault flags never rise together. They also check that a fault never comes with a fresh request, that a non-matching primary opcode leaves nothing behind, and that the context and hint follow the values at acceptance. Only the bench scenarios can show exact address arithmetic: the zero-base substitution, wrap-around past 2^64, and clearing of unaligned low bits. The same holds for the full decode of neighbouring extended opcodes and a set bit 31, for the four combinations of privilege and vector enable, and for reset in the middle of a stalled request.

// File: rtl/xctx_vst_pkg.sv
// Package: encodings and decoded-field type shared by the store issue logic.
// Assumes bit 0 of the instruction word as written in the encoding is insn[31].
package xctx_vst_pkg;
    localparam logic [5:0] PRIMARY_OP   = 6'd31;
    localparam logic [9:0] EXT_PLAIN    = 10'd807;
    localparam logic [9:0] EXT_LOWREUSE = 10'd775;
    localparam int         STORE_BYTES  = 16;

    typedef struct packed {
        logic       hit;
        logic       low_reuse;
        logic [4:0] vreg;
        logic       base_is_zero;
    } vst_dec_t;

    typedef enum logic [1:0] {
        ISSUE_NONE,
        ISSUE_STORE,
        ISSUE_PRIV_FAULT,
        ISSUE_VEC_FAULT
    } vst_issue_e;
endpackage

// File: rtl/xctx_vst_decode.sv
// Decoder: recognises the two vector-store encodings and extracts fields.
// Assumes a combinational path only; the index register number is not needed
// because the operand value arrives already read.
module xctx_vst_decode
    import xctx_vst_pkg::*;
(
    input  logic [31:0] insn,
    output vst_dec_t    dec
);
    logic [5:0] prim;
    logic [9:0] ext;
    logic       ext_plain;
    logic       ext_low;

    // Split the word into the fields this block inspects.
    always_comb begin
        prim      = insn[31:26];
        ext       = insn[10:1];
        ext_plain = (ext == EXT_PLAIN);
        ext_low   = (ext == EXT_LOWREUSE);
    end

    // Build the decoded record; a miss leaves hit low.
    always_comb begin
        dec.hit          = (prim == PRIMARY_OP) && !insn[0] && (ext_plain || ext_low);
        dec.low_reuse    = ext_low;
        dec.vreg         = insn[25:21];
        dec.base_is_zero = (insn[20:16] == 5'd0);
    end
endmodule

// File: rtl/xctx_vst_agen.sv
// Address generator: base (or zero) plus index, wrapped, then aligned down.
// Assumes ALIGN_BITS < ADDR_W; no overflow flag is produced.
module xctx_vst_agen #(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 4
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              base_is_zero,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] ea;

    // Form the effective address modulo 2^ADDR_W.
    always_comb begin
        base_eff = base_is_zero ? '0 : base_val;
        ea       = base_eff + index_val;
    end

    // Clear the low address bits when alignment is requested.
    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign addr = {ea[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end else begin : g_noalign
            assign addr = ea;
        end
    endgenerate
endmodule

// File: rtl/xctx_vst_slot.sv
// Output slot: one registered store request with valid/ready, plus the
// one-cycle fault pulses. Assumes the caller only sets take when in_ready is high.
module xctx_vst_slot
    import xctx_vst_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PID_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  vst_issue_e        kind,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [4:0]        vreg_in,
    input  logic              user_in,
    input  logic              as_in,
    input  logic [PID_W-1:0]  pid_in,
    input  logic              low_in,
    input  logic              st_ready,
    output logic              slot_free,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [4:0]        st_vreg,
    output logic              st_user,
    output logic              st_as,
    output logic [PID_W-1:0]  st_pid,
    output logic              st_low_reuse,
    output logic              exc_priv,
    output logic              exc_vec
);
    logic load;

    // A permitted store accepted this cycle fills the slot.
    always_comb begin
        load      = take && (kind == ISSUE_STORE);
        slot_free = !st_valid || st_ready;
    end

    // Valid bit: set on load, cleared when drained.
    always_ff @(posedge clk) begin
        if (!rst_n)          st_valid <= 1'b0;
        else if (load)       st_valid <= 1'b1;
        else if (st_ready)   st_valid <= 1'b0;
    end

    // Payload capture; held otherwise so it stays stable under back-pressure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_addr      <= '0;
            st_vreg      <= '0;
            st_user      <= 1'b0;
            st_as        <= 1'b0;
            st_pid       <= '0;
            st_low_reuse <= 1'b0;
        end else if (load) begin
            st_addr      <= addr_in;
            st_vreg      <= vreg_in;
            st_user      <= user_in;
            st_as        <= as_in;
            st_pid       <= pid_in;
            st_low_reuse <= low_in;
        end
    end

    // Fault pulses last exactly one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_priv <= 1'b0;
            exc_vec  <= 1'b0;
        end else begin
            exc_priv <= take && (kind == ISSUE_PRIV_FAULT);
            exc_vec  <= take && (kind == ISSUE_VEC_FAULT);
        end
    end
endmodule

// File: rtl/xctx_vst_issue.sv
// Top: decodes an external-context vector store, checks privilege and vector
// enable, and issues an aligned 16-byte store request carrying the external
// translation context. Assumes operand values are read before presentation.
module xctx_vst_issue
    import xctx_vst_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PID_W      = 14,
    parameter int ALIGN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       insn,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              cur_user,
    input  logic              vec_en,
    input  logic              xctx_user,
    input  logic              xctx_as,
    input  logic [PID_W-1:0]  xctx_pid,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [ADDR_W-1:0] st_addr,
    output logic [4:0]        st_vreg,
    output logic [4:0]        st_bytes,
    output logic              st_user,
    output logic              st_as,
    output logic [PID_W-1:0]  st_pid,
    output logic              st_low_reuse,
    output logic              exc_priv,
    output logic              exc_vec
);
    vst_dec_t          dec;
    logic [ADDR_W-1:0] addr;
    vst_issue_e        kind;
    logic              slot_free;
    logic              take;

    xctx_vst_decode u_dec (.insn(insn), .dec(dec));

    xctx_vst_agen #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_agen (
        .base_val(base_val), .index_val(index_val),
        .base_is_zero(dec.base_is_zero), .addr(addr)
    );

    // Pick the outcome; the privilege fault outranks the vector fault.
    always_comb begin
        if (!dec.hit)      kind = ISSUE_NONE;
        else if (cur_user) kind = ISSUE_PRIV_FAULT;
        else if (!vec_en)  kind = ISSUE_VEC_FAULT;
        else               kind = ISSUE_STORE;
    end

    // Handshake on the input side follows slot availability.
    always_comb begin
        in_ready = slot_free;
        take     = in_valid && slot_free;
        st_bytes = 5'(STORE_BYTES);
    end

    xctx_vst_slot #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .take(take), .kind(kind),
        .addr_in(addr), .vreg_in(dec.vreg), .user_in(xctx_user),
        .as_in(xctx_as), .pid_in(xctx_pid), .low_in(dec.low_reuse),
        .st_ready(st_ready), .slot_free(slot_free), .st_valid(st_valid),
        .st_addr(st_addr), .st_vreg(st_vreg), .st_user(st_user),
        .st_as(st_as), .st_pid(st_pid), .st_low_reuse(st_low_reuse),
        .exc_priv(exc_priv), .exc_vec(exc_vec)
    );
endmodule

// File: rtl/xctx_vst_checker.sv
// Checker: temporal rules of the store issue block, bound to the top.
// Assumes observation of top-level ports only.
module xctx_vst_checker #(
    parameter int ADDR_W = 64,
    parameter int PID_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [31:0]       insn,
    input logic              cur_user,
    input logic              vec_en,
    input logic              xctx_user,
    input logic              xctx_as,
    input logic [PID_W-1:0]  xctx_pid,
    input logic              st_valid,
    input logic              st_ready,
    input logic [ADDR_W-1:0] st_addr,
    input logic [4:0]        st_vreg,
    input logic              st_user,
    input logic              st_as,
    input logic [PID_W-1:0]  st_pid,
    input logic              st_low_reuse,
    input logic              exc_priv,
    input logic              exc_vec
);
    assert_primary_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && insn[31:26] != 6'd31) |=> (!st_valid && !exc_priv && !exc_vec));

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_addr[3:0] == 4'd0));

    assert_hint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!st_valid || (st_low_reuse == ($past(insn[10:1]) == 10'd775))));

    assert_context_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!st_valid || (st_pid == $past(xctx_pid) &&
            st_user == $past(xctx_user) && st_as == $past(xctx_as))));

    assert_priv_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cur_user) |=> !st_valid);

    assert_vec_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !vec_en) |=> !st_valid);

    assert_one_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_priv && exc_vec));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_vreg) &&
            $stable(st_pid) && $stable(st_user) && $stable(st_as) && $stable(st_low_reuse)));

    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |-> !in_ready);

    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (!st_valid && !exc_priv && !exc_vec));
endmodule

bind xctx_vst_issue xctx_vst_checker #(.ADDR_W(ADDR_W), .PID_W(PID_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .cur_user(cur_user), .vec_en(vec_en), .xctx_user(xctx_user),
    .xctx_as(xctx_as), .xctx_pid(xctx_pid), .st_valid(st_valid),
    .st_ready(st_ready), .st_addr(st_addr), .st_vreg(st_vreg),
    .st_user(st_user), .st_as(st_as), .st_pid(st_pid),
    .st_low_reuse(st_low_reuse), .exc_priv(exc_priv), .exc_vec(exc_vec)
);

// File: tb/xctx_vst_issue_tb_top.sv
// Bench: a vector table walked by one loop, then directed back-pressure and
// reset cases. Expected values come from a model of the requirements.
module xctx_vst_issue_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PID_W      = 14;

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] base;
        logic [63:0] idx;
        logic        cu;
        logic        ve;
        logic [1:0]  kind;   // 0 none, 1 store, 2 priv fault, 3 vector fault
    } vec_t;

    function automatic logic [31:0] enc(input logic [5:0] p, input int ext,
                                        input logic [4:0] vs, input logic [4:0] ra, input logic b31);
        return {p, vs, ra, 5'd7, 10'(ext), b31};
    endfunction

    localparam int NV = 12;
    localparam vec_t TV [NV] = '{
        '{enc(6'd31, 807, 5'd9,  5'd3, 1'b0), 64'h1000, 64'h23, 1'b0, 1'b1, 2'd1},
        '{enc(6'd31, 775, 5'd31, 5'd5, 1'b0), 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 1'b0, 1'b1, 2'd1},
        '{enc(6'd31, 807, 5'd1,  5'd0, 1'b0), 64'hDEAD, 64'h1234_567F, 1'b0, 1'b1, 2'd1},
        '{enc(6'd31, 775, 5'd0,  5'd0, 1'b0), 64'hBEEF, 64'hF, 1'b0, 1'b1, 2'd1},
        '{enc(6'd31, 807, 5'd4,  5'd2, 1'b0), 64'h40, 64'h4, 1'b1, 1'b1, 2'd2},
        '{enc(6'd31, 807, 5'd4,  5'd2, 1'b0), 64'h40, 64'h4, 1'b1, 1'b0, 2'd2},
        '{enc(6'd31, 775, 5'd6,  5'd2, 1'b0), 64'h40, 64'h4, 1'b0, 1'b0, 2'd3},
        '{enc(6'd31, 806, 5'd6,  5'd2, 1'b0), 64'h40, 64'h4, 1'b0, 1'b1, 2'd0},
        '{enc(6'd30, 807, 5'd6,  5'd2, 1'b0), 64'h40, 64'h4, 1'b0, 1'b1, 2'd0},
        '{enc(6'd31, 807, 5'd6,  5'd2, 1'b1), 64'h40, 64'h4, 1'b0, 1'b1, 2'd0},
        '{enc(6'd31, 103, 5'd6,  5'd2, 1'b0), 64'h40, 64'h4, 1'b1, 1'b0, 2'd0},
        '{enc(6'd31, 775, 5'd17, 5'd8, 1'b0), 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, 2'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [31:0] insn = '0;
    logic [63:0] base_val = '0, index_val = '0;
    logic cur_user = 1'b0, vec_en = 1'b1, xctx_user = 1'b0, xctx_as = 1'b0;
    logic [PID_W-1:0] xctx_pid = '0;
    logic st_valid, st_ready = 1'b1;
    logic [63:0] st_addr;
    logic [4:0] st_vreg, st_bytes;
    logic st_user, st_as, st_low_reuse, exc_priv, exc_vec;
    logic [PID_W-1:0] st_pid;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xctx_vst_issue #(.PID_W(PID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .insn(insn), .base_val(base_val), .index_val(index_val),
        .cur_user(cur_user), .vec_en(vec_en), .xctx_user(xctx_user),
        .xctx_as(xctx_as), .xctx_pid(xctx_pid), .st_valid(st_valid),
        .st_ready(st_ready), .st_addr(st_addr), .st_vreg(st_vreg),
        .st_bytes(st_bytes), .st_user(st_user), .st_as(st_as),
        .st_pid(st_pid), .st_low_reuse(st_low_reuse),
        .exc_priv(exc_priv), .exc_vec(exc_vec)
    );

    function automatic logic [63:0] model_addr(input logic [31:0] w, input logic [63:0] b, input logic [63:0] x);
        logic [63:0] s;
        s = ((w[20:16] == 5'd0) ? 64'd0 : b) + x;
        return s & ~64'hF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic present(input logic [31:0] w, input logic [63:0] b, input logic [63:0] x,
                           input logic cu, input logic ve, input logic xu, input logic xa,
                           input logic [PID_W-1:0] pid);
        insn = w; base_val = b; index_val = x; cur_user = cu; vec_en = ve;
        xctx_user = xu; xctx_as = xa; xctx_pid = pid; in_valid = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: state after reset
        chk(!st_valid && !exc_priv && !exc_vec, "R11 reset outputs", {st_valid, exc_priv, exc_vec}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready, "R10 ready when empty", in_ready, 1);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] ea;
            logic xu, xa;
            logic [PID_W-1:0] pid;
            xu = i[0]; xa = i[1]; pid = PID_W'(i * 37 + 5);
            ea = model_addr(TV[i].insn, TV[i].base, TV[i].idx);
            st_ready = 1'b1;
            present(TV[i].insn, TV[i].base, TV[i].idx, TV[i].cu, TV[i].ve, xu, xa, pid);
            @(negedge clk);
            in_valid = 1'b0;
            chk(st_valid == (TV[i].kind == 2'd1), "R1 R6 R7 store issued", st_valid, TV[i].kind == 2'd1);
            chk(exc_priv == (TV[i].kind == 2'd2), "R6 R8 exc_priv", exc_priv, TV[i].kind == 2'd2);
            chk(exc_vec == (TV[i].kind == 2'd3), "R7 R8 exc_vec", exc_vec, TV[i].kind == 2'd3);
            if (TV[i].kind == 2'd1) begin
                chk(st_addr == ea, "R3 address", st_addr, ea);
                chk(st_vreg == TV[i].insn[25:21], "R2 vreg", st_vreg, TV[i].insn[25:21]);
                chk(st_low_reuse == (TV[i].insn[10:1] == 10'd775), "R4 hint", st_low_reuse, TV[i].insn[10:1] == 10'd775);
                chk(st_user == xu && st_as == xa && st_pid == pid, "R5 context",
                    {st_user, st_as, st_pid}, {xu, xa, pid});
                chk(st_bytes == 5'd16, "R5 size", st_bytes, 16);
            end
        end

        // R9/R10: back-pressure holds request A and blocks B
        @(negedge clk);
        st_ready = 1'b0;
        present(enc(6'd31, 807, 5'd12, 5'd3, 1'b0), 64'h5000, 64'h7, 1'b0, 1'b1, 1'b1, 1'b0, 14'd99);
        @(negedge clk);
        present(enc(6'd31, 775, 5'd13, 5'd3, 1'b0), 64'h9000, 64'h1F, 1'b0, 1'b1, 1'b0, 1'b1, 14'd7);
        chk(st_valid && st_addr == 64'h5000, "R10 A issued", st_addr, 64'h5000);
        chk(!in_ready, "R10 stalled", in_ready, 0);
        @(negedge clk);
        chk(st_valid && st_addr == 64'h5000 && st_vreg == 5'd12 && st_pid == 14'd99,
            "R9 held stable", st_addr, 64'h5000);
        st_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(st_valid && st_addr == 64'h9010 && st_vreg == 5'd13 && st_low_reuse,
            "R10 B after drain", st_addr, 64'h9010);
        @(negedge clk);
        chk(!st_valid, "R10 drained", st_valid, 0);

        // R11: reset during a stalled request
        st_ready = 1'b0;
        present(enc(6'd31, 807, 5'd2, 5'd0, 1'b0), 64'h0, 64'h100, 1'b0, 1'b1, 1'b0, 1'b0, 14'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(st_valid, "R11 loaded before reset", st_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!st_valid && !exc_priv && !exc_vec, "R11 mid-run reset", st_valid, 0);
        rst_n = 1'b1;
        st_ready = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule